// File: doc/BRIEF.md
# Master-Side Transfer Holding Stage

This block sits between one bus master and its port into a crossbar interconnect. The bus protocol is pipelined: each transfer has an address and control phase. When the slave path is free, the stage passes the master's phase through to the slave side in the same cycle, with no added latency. When the slave path cannot take the phase in the cycle it is offered, the stage copies that phase into a holding register. It then stalls the master until the slave path accepts the held copy.

Two strobes mark the events inside the stage. The capture strobe is high in the cycle a phase is written into the holding register. The replay strobe is high in every cycle the held copy is the one being presented to the slave. The slave side can lose its grant in the middle of a burst. When that happens, the held beat is later replayed with its sequential marker cleared, so the slave sees a fresh start at the correct next address. The master's following beats then continue the burst.

Top module: `input_stage_buffer`

## Requirements
- R1: With nothing held, the slave-side valid, address, control and sequential flag equal the master-side inputs in the same cycle, `m_ready` is 1 and `drive_stb` is 0.
- R2: With nothing held, a cycle with `m_valid`=1 and `s_accept`=0 raises `load_stb` in that same cycle, and the offered address, control and flag are captured at the next clock edge.
- R3: In the cycle after a capture, `drive_stb` is 1, `s_valid` is 1, and `s_addr`/`s_ctrl` carry the captured values. This is the one-cycle load-to-replay spacing.
- R4: While a phase is held, `m_ready` is 0, `load_stb` is 0, and changes on the master-side inputs have no effect on `s_addr` or `s_ctrl`.
- R5: A held phase is released at the clock edge of a cycle in which `s_accept` is 1. In the next cycle `drive_stb` is 0 and `m_ready` is 1.
- R6: A cycle with `m_valid`=0 and nothing held gives `load_stb`=0 and `s_valid`=0, and nothing is captured.
- R7: A held phase is always replayed with `s_seq`=0 (0 marks the first beat of a burst, 1 a following beat). This holds even when it was captured with `m_seq`=1, and the address is unchanged.
- R8: After synchronous active-low reset, nothing is held: `drive_stb`=0, `m_ready`=1, and the slave side follows the master side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_valid | input | 1 | Master offers a transfer phase |
| m_addr | input | AW | Master address |
| m_ctrl | input | CW | Master control bits (direction, size and the like) |
| m_seq | input | 1 | 1 = following beat of a burst, 0 = first beat |
| m_ready | output | 1 | Stage can take a new phase from the master |
| s_valid | output | 1 | Phase presented toward the slave |
| s_addr | output | AW | Address presented toward the slave |
| s_ctrl | output | CW | Control presented toward the slave |
| s_seq | output | 1 | Sequential flag presented toward the slave |
| s_accept | input | 1 | Slave path granted and taking the presented phase |
| load_stb | output | 1 | Holding register captures in this cycle |
| drive_stb | output | 1 | Held copy is being presented in this cycle |

## Verification
The bench targets four failure cases.

- Back-to-back stalls, where the slave path refuses several cycles in a row. A stage that recaptures while already holding would swap in the stalled master's newer address, so the slave would see the wrong beat.
- A release immediately followed by a fresh refusal. A design that stays stalled one cycle too long, or that releases without the accept, shows up as a wrong `m_ready` or `drive_stb`.
- A sequential beat that gets caught in the holding register. It must go out as a first beat; a design that forwards the flag unchanged would resume a burst the slave no longer tracks.
- Idle cycles mixed with refusals. A stage that captures while deselected shows up as a spurious capture strobe.

// File: rtl/ist_pkg.sv
// Package: shared types for the master-side holding stage.
// Assumes: one bit marks a burst beat as first (0) or following (1).
package ist_pkg;
    typedef enum logic {
        BEAT_FIRST = 1'b0,
        BEAT_NEXT  = 1'b1
    } beat_e;

    localparam int DEF_AW = 32;
    localparam int DEF_CW = 4;
endpackage

// File: rtl/ist_capture_ctl.sv
// Module: ist_capture_ctl
// Decides when the holding register captures and when the held phase is
// released. Assumes the slave side samples its inputs only when s_accept is 1.
module ist_capture_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic m_valid,
    input  logic s_accept,
    output logic load,
    output logic held
);
    logic held_q;

    // Capture only when idle, offered and refused
    always_comb begin
        load = !held_q && m_valid && !s_accept;
    end

    // Pending flag: set on capture, cleared on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= 1'b0;
        else if (load)
            held_q <= 1'b1;
        else if (held_q && s_accept)
            held_q <= 1'b0;
    end

    assign held = held_q;

    // R2
    load_follows_refusal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> held);
    // R5
    release_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && s_accept) |=> !held);
    // R4
    hold_persists_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !s_accept) |=> held);
endmodule

// File: rtl/ist_hold_regs.sv
// Module: ist_hold_regs
// Storage for one captured address/control phase. Assumes load is only
// raised when the previous content is no longer needed.
module ist_hold_regs #(
    parameter int W          = 37,
    parameter bit CLEAR_DATA = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    generate
        if (CLEAR_DATA) begin : g_clr
            // Capture the phase; zero it under reset
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q_r <= '0;
                else if (load)
                    q_r <= d;
            end
        end else begin : g_noclr
            // Capture the phase; data needs no reset
            always_ff @(posedge clk) begin
                if (load)
                    q_r <= d;
            end
        end
    endgenerate

    assign q = q_r;

    // R4
    hold_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/ist_slave_mux.sv
// Module: ist_slave_mux
// Picks the live master phase or the held copy for the slave side and
// rewrites the burst flag of a replayed beat to first-beat.
module ist_slave_mux
    import ist_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 4
) (
    input  logic          held,
    input  logic          m_valid,
    input  logic [AW-1:0] m_addr,
    input  logic [CW-1:0] m_ctrl,
    input  logic          m_seq,
    input  logic [AW-1:0] h_addr,
    input  logic [CW-1:0] h_ctrl,
    input  beat_e         h_kind,
    output logic          s_valid,
    output logic [AW-1:0] s_addr,
    output logic [CW-1:0] s_ctrl,
    output logic          s_seq
);
    beat_e replay_kind;

    // A replayed following beat restarts the burst as a first beat
    always_comb begin
        replay_kind = (h_kind == BEAT_NEXT) ? BEAT_FIRST : h_kind;
    end

    // Slave-side selection between held copy and live master phase
    always_comb begin
        if (held) begin
            s_valid = 1'b1;
            s_addr  = h_addr;
            s_ctrl  = h_ctrl;
            s_seq   = replay_kind;
        end else begin
            s_valid = m_valid;
            s_addr  = m_addr;
            s_ctrl  = m_ctrl;
            s_seq   = m_seq;
        end
    end
endmodule

// File: rtl/input_stage_buffer.sv
// Module: input_stage_buffer (top)
// Master-side stage of a crossbar port: passes phases through when the slave
// path accepts, otherwise holds one phase and stalls the master until it is
// accepted. Assumes the master keeps its phase while m_ready is 0.
module input_stage_buffer
    import ist_pkg::*;
#(
    parameter int AW = DEF_AW,
    parameter int CW = DEF_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m_valid,
    input  logic [AW-1:0] m_addr,
    input  logic [CW-1:0] m_ctrl,
    input  logic          m_seq,
    output logic          m_ready,
    output logic          s_valid,
    output logic [AW-1:0] s_addr,
    output logic [CW-1:0] s_ctrl,
    output logic          s_seq,
    input  logic          s_accept,
    output logic          load_stb,
    output logic          drive_stb
);
    localparam int HW = AW + CW + 1;

    logic          held;
    logic          load;
    logic [HW-1:0] hold_d;
    logic [HW-1:0] hold_q;
    logic [AW-1:0] h_addr;
    logic [CW-1:0] h_ctrl;
    beat_e         h_kind;

    ist_capture_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .m_valid  (m_valid),
        .s_accept (s_accept),
        .load     (load),
        .held     (held)
    );

    // Pack the master phase for storage
    always_comb begin
        hold_d = {m_addr, m_ctrl, m_seq};
    end

    ist_hold_regs #(.W(HW), .CLEAR_DATA(1'b1)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     (hold_d),
        .q     (hold_q)
    );

    // Unpack the held phase
    always_comb begin
        h_addr = hold_q[HW-1 -: AW];
        h_ctrl = hold_q[CW:1];
        h_kind = beat_e'(hold_q[0]);
    end

    ist_slave_mux #(.AW(AW), .CW(CW)) u_mux (
        .held    (held),
        .m_valid (m_valid),
        .m_addr  (m_addr),
        .m_ctrl  (m_ctrl),
        .m_seq   (m_seq),
        .h_addr  (h_addr),
        .h_ctrl  (h_ctrl),
        .h_kind  (h_kind),
        .s_valid (s_valid),
        .s_addr  (s_addr),
        .s_ctrl  (s_ctrl),
        .s_seq   (s_seq)
    );

    assign m_ready   = !held;
    assign load_stb  = load;
    assign drive_stb = held;

    // R3
    load_then_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (drive_stb && s_valid));
    // R3
    captured_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (s_addr == $past(m_addr) && s_ctrl == $past(m_ctrl)));
    // R6
    no_load_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !m_valid |-> !load_stb);
    // R7
    replay_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_stb |-> !s_seq);
    // R4
    stall_holds_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_stb && !s_accept) |=> (drive_stb && $stable(s_addr) && !m_ready));
    // R8
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!drive_stb && m_ready));
endmodule

// File: tb/tb_input_stage_buffer.sv
module tb_input_stage_buffer;
    localparam int AW = 32;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          m_valid;
    logic [AW-1:0] m_addr;
    logic [CW-1:0] m_ctrl;
    logic          m_seq;
    logic          m_ready;
    logic          s_valid;
    logic [AW-1:0] s_addr;
    logic [CW-1:0] s_ctrl;
    logic          s_seq;
    logic          s_accept;
    logic          load_stb;
    logic          drive_stb;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model state
    bit            eh;
    logic [AW-1:0] ea;
    logic [CW-1:0] ec;

    always #2.5 clk = ~clk;

    input_stage_buffer #(.AW(AW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_addr(m_addr),
        .m_ctrl(m_ctrl), .m_seq(m_seq), .m_ready(m_ready), .s_valid(s_valid),
        .s_addr(s_addr), .s_ctrl(s_ctrl), .s_seq(s_seq), .s_accept(s_accept),
        .load_stb(load_stb), .drive_stb(drive_stb)
    );

    function automatic void chk(bit ok, string req, string what,
                                logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    // expected outputs from the model for the current inputs
    function automatic logic [AW-1:0] exp_addr();
        return eh ? ea : m_addr;
    endfunction

    // one cycle: drive at negedge, compare before posedge, advance model
    task automatic step(bit v, logic [AW-1:0] a, logic [CW-1:0] c, bit sq, bit acc);
        string rq;
        bit    xl;
        @(negedge clk);
        m_valid = v; m_addr = a; m_ctrl = c; m_seq = sq; s_accept = acc;
        #1;
        if (eh) begin
            chk(m_ready == 1'b0, "R4", "m_ready", m_ready, 0);
            chk(load_stb == 1'b0, "R4", "load_stb", load_stb, 0);
            chk(drive_stb == 1'b1, "R3", "drive_stb", drive_stb, 1);
            chk(s_valid == 1'b1, "R3", "s_valid", s_valid, 1);
            chk(s_addr == ea, "R4", "s_addr", s_addr, ea);
            chk(s_ctrl == ec, "R4", "s_ctrl", s_ctrl, ec);
            chk(s_seq == 1'b0, "R7", "s_seq", s_seq, 0);
        end else begin
            xl = v && !acc;
            rq = v ? "R2" : "R6";
            chk(load_stb == xl, rq, "load_stb", load_stb, xl);
            chk(m_ready == 1'b1, "R1", "m_ready", m_ready, 1);
            chk(drive_stb == 1'b0, "R1", "drive_stb", drive_stb, 0);
            chk(s_valid == v, v ? "R1" : "R6", "s_valid", s_valid, v);
            chk(s_addr == exp_addr(), "R1", "s_addr", s_addr, exp_addr());
            chk(s_ctrl == c, "R1", "s_ctrl", s_ctrl, c);
            chk(s_seq == sq, "R1", "s_seq", s_seq, sq);
        end
        @(posedge clk);
        if (!eh && v && !acc) begin
            eh = 1'b1; ea = a; ec = c;
        end else if (eh && acc) begin
            eh = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; m_valid = 1'b0; m_addr = '0; m_ctrl = '0;
        m_seq = 1'b0; s_accept = 1'b0;
        eh = 1'b0; ea = '0; ec = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8: reset state
        chk(drive_stb == 1'b0, "R8", "drive_stb", drive_stb, 0);
        chk(m_ready == 1'b1, "R8", "m_ready", m_ready, 1);
        chk(s_valid == 1'b0, "R8", "s_valid", s_valid, 0);

        // R1: pass-through accepted
        step(1, 32'h0000_1000, 4'h3, 0, 1);
        // R6: idle, slave refusing: no capture
        step(0, 32'h0000_2000, 4'h1, 0, 0);
        // R2/R3/R4: capture, then stall while master changes inputs
        step(1, 32'h0000_3000, 4'h5, 0, 0);
        step(1, 32'hDEAD_0000, 4'hA, 1, 0);
        step(1, 32'hBEEF_0000, 4'hB, 0, 0);
        // R5: release, then immediate new refusal
        step(1, 32'hBEEF_0000, 4'hB, 0, 1);
        step(1, 32'h0000_3004, 4'h5, 1, 0);
        // R7: held following beat replayed as first beat
        step(1, 32'h0000_3008, 4'h5, 1, 1);
        step(1, 32'h0000_3008, 4'h5, 1, 1);
        // R5: after release master is ready again
        step(0, 32'h0, 4'h0, 0, 1);

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, $urandom, 4'($urandom), 1'($urandom),
                 ($urandom % 3) != 0);
        end

        // R8: reset while holding clears the pending phase
        step(1, 32'h0000_4000, 4'h2, 0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        eh = 1'b0;
        #1;
        chk(drive_stb == 1'b0, "R8", "drive_stb after reset", drive_stb, 0);
        chk(m_ready == 1'b1, "R8", "m_ready after reset", m_ready, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule